// File: doc/BRIEF.md
# Serial In-System Programming Command Sequencer

This block sits between a synchronous serial slave port, clocked by an external host, and the control side of an on-chip flash array. The host shifts in one-byte opcodes and their operand bytes. The sequencer decodes them into page erase, whole-array erase, single and burst byte reads and writes, and option-byte reads. It shifts read results back out on the next byte transfer. It also generates a one-cycle reset request when the host asks to leave programming mode.

The port stays closed until the entry pin has been seen high and then low for a run of consecutive samples. After that, the first command must load the write-timing register. Every flash modification also needs a fresh unlock: a key byte must match a fixed six-bit pattern in its upper bits, and that unlock is used up by each completed write, erase or burst write.

The serial side has no back-pressure. The host paces itself: after the last byte of a command it waits until the flash operation has finished and any result byte is loaded. The flash request follows valid/ready rules. `fl_valid` stays high with stable fields until `fl_ready` is seen, at most one request is outstanding, and `fl_done` completes it.

Top module: `isp_sequencer`

## Requirements
- R1: The sequencer becomes active only after the synchronised entry pin has been high and then low for DEB_LEN consecutive clock samples. A shorter low pulse leaves it inactive, and serial bytes sent while inactive have no effect.
- R2: Until a timing write (opcode 0x01 followed by one data byte) completes, any other opcode pulses `cmd_reject` and issues no flash request. The timing byte appears on `timing_val`.
- R3: A key write (0x02 followed by a data byte) opens `wr_unlocked` only if data bits 7..2 equal 100110, whatever bits 1..0 hold. Any other value closes it.
- R4: While locked, a single write (0x31), page erase (0x11) or mass erase (0x10) pulses `cmd_reject` and makes no flash request. A locked burst write still consumes its count of data bytes, so the framing of the next command is kept.
- R5: `wr_unlocked` closes after each completed single write, erase, or whole burst write.
- R6: Single read 0x30, addr-hi, addr-lo issues one flash read (op code 0). The returned byte is shifted out MSB first during the next byte transfer, and the byte the host sends in that transfer is a dummy that is discarded.
- R7: Burst read 0x32, addr-hi, addr-lo, n issues n reads at consecutive addresses, each result returned on one dummy transfer. If n = 0, no request is made.
- R8: Write 0x31, addr-hi, addr-lo, data issues one flash write (op code 1). Burst write 0x33, addr-hi, addr-lo, n, then n data bytes, writes them to consecutive addresses.
- R9: Option read 0x20 returns the option byte on the next transfer: bit 0 is the boot-select flag, bit 1 the protection flag, and the reset value is 0x03. A page erase (op code 2) clears bit 0. A mass erase (op code 3) clears bits 0 and 1, and is the only way to clear bit 1.
- R10: Exit 0x7F pulses `exit_reset` for one cycle and drops `isp_active`. A new entry sequence and a new timing write are then needed.
- R11: The flash request keeps `fl_valid`, `fl_op`, `fl_addr` and `fl_wdata` stable until accepted, and no new request is raised before `fl_done`.
- R12: An opcode outside the supported set pulses `cmd_reject` and is otherwise ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entry_pin | input | 1 | Programming entry level, high while held in entry |
| ser_clk | input | 1 | Host serial clock, data sampled on its rising edge |
| ser_din | input | 1 | Host-to-block serial data, MSB first |
| ser_dout | output | 1 | Block-to-host serial data, MSB first |
| fl_valid | output | 1 | Flash request valid |
| fl_ready | input | 1 | Flash accepts the request |
| fl_op | output | 2 | 0 read, 1 write, 2 page erase, 3 mass erase |
| fl_addr | output | 16 | Byte or page address |
| fl_wdata | output | 8 | Write data |
| fl_done | input | 1 | One-cycle completion of the accepted request |
| fl_rdata | input | 8 | Read data, valid with fl_done |
| isp_active | output | 1 | Command port open |
| timing_val | output | 8 | Write-timing register |
| wr_unlocked | output | 1 | Modification unlock state |
| cmd_reject | output | 1 | One-cycle pulse when a command is refused |
| exit_reset | output | 1 | One-cycle reset request on exit |

## Verification
The assertions assume a flash side that raises `fl_done` for a single cycle and only for a request it has accepted. They also assume a host that starts no new byte before the sequencer has finished the previous one. The stimulus keeps to this in two ways. The flash model accepts within three cycles and finishes within six. The host inserts a fixed idle gap, well beyond that worst case, after every byte, and uses dummy transfers to collect read results.

// File: rtl/isp_seq_pkg.sv
package isp_seq_pkg;

  typedef enum logic [1:0] {
    FL_READ       = 2'd0,
    FL_WRITE      = 2'd1,
    FL_PAGE_ERASE = 2'd2,
    FL_MASS_ERASE = 2'd3
  } fl_op_e;

  localparam logic [7:0] OPC_TIMING = 8'h01;
  localparam logic [7:0] OPC_KEY    = 8'h02;
  localparam logic [7:0] OPC_MASS   = 8'h10;
  localparam logic [7:0] OPC_PAGE   = 8'h11;
  localparam logic [7:0] OPC_OPT    = 8'h20;
  localparam logic [7:0] OPC_RD     = 8'h30;
  localparam logic [7:0] OPC_WR     = 8'h31;
  localparam logic [7:0] OPC_BRD    = 8'h32;
  localparam logic [7:0] OPC_BWR    = 8'h33;
  localparam logic [7:0] OPC_EXIT   = 8'h7F;

  localparam logic [5:0] UNLOCK_PATTERN = 6'b100110;
  localparam int         BOOT_FLAG_BIT  = 0;
  localparam int         PROT_FLAG_BIT  = 1;

  // number of operand bytes that follow each opcode
  function automatic logic [1:0] operand_bytes(input logic [7:0] opc);
    case (opc)
      OPC_TIMING, OPC_KEY:         return 2'd1;
      OPC_PAGE, OPC_RD:            return 2'd2;
      OPC_WR, OPC_BRD, OPC_BWR:    return 2'd3;
      default:                     return 2'd0;
    endcase
  endfunction

  function automatic logic opcode_known(input logic [7:0] opc);
    case (opc)
      OPC_TIMING, OPC_KEY, OPC_MASS, OPC_PAGE, OPC_OPT,
      OPC_RD, OPC_WR, OPC_BRD, OPC_BWR, OPC_EXIT: return 1'b1;
      default:                                    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/isp_ser_shift.sv
module isp_ser_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [BYTE_W-1:0] tx_data_i
);
  localparam int CW = $clog2(BYTE_W);

  logic [2:0]        sclk_sync;
  logic [1:0]        sdi_sync;
  logic [CW-1:0]     bitcnt_q;
  logic [BYTE_W-1:0] rxsh_q;
  logic [BYTE_W-1:0] txsh_q;
  logic              rx_valid_q;
  logic              rise;

  assign rise       = sclk_sync[1] & ~sclk_sync[2];
  assign tx_ready_o = en && (bitcnt_q == '0) && !rise;
  assign sdo_o      = txsh_q[BYTE_W-1];
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rxsh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync  <= '0;
      sdi_sync   <= '0;
      bitcnt_q   <= '0;
      rxsh_q     <= '0;
      txsh_q     <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      sclk_sync  <= {sclk_sync[1:0], sclk_i};
      sdi_sync   <= {sdi_sync[0], sdi_i};
      rx_valid_q <= 1'b0;
      if (!en) begin
        bitcnt_q <= '0;
        rxsh_q   <= '0;
        txsh_q   <= '0;
      end else if (rise) begin
        rxsh_q <= {rxsh_q[BYTE_W-2:0], sdi_sync[1]};
        txsh_q <= {txsh_q[BYTE_W-2:0], 1'b0};
        if (bitcnt_q == CW'(BYTE_W - 1)) begin
          bitcnt_q   <= '0;
          rx_valid_q <= 1'b1;
        end else begin
          bitcnt_q <= bitcnt_q + 1'b1;
        end
      end else if (tx_valid_i && tx_ready_o) begin
        txsh_q <= tx_data_i;
      end
    end
  end

  // R1: a byte can only complete while the port is open
  a_r1_no_byte_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(en));

endmodule

// File: rtl/isp_entry_deb.sv
module isp_entry_deb #(
  parameter int DEB_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic clear_i,
  output logic active_o
);
  localparam int CW = $clog2(DEB_LEN + 1);

  logic [1:0]    pin_sync;
  logic          pin_s;
  logic          armed_q;
  logic          active_q;
  logic [CW-1:0] run_q;

  assign pin_s    = pin_sync[1];
  assign active_o = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync <= '0;
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      run_q    <= '0;
    end else begin
      pin_sync <= {pin_sync[0], pin_i};
      if (clear_i) begin
        active_q <= 1'b0;
        armed_q  <= 1'b0;
        run_q    <= '0;
      end else if (!active_q) begin
        if (pin_s) begin
          armed_q <= 1'b1;
          run_q   <= '0;
        end else if (armed_q) begin
          if (run_q == CW'(DEB_LEN - 1)) begin
            active_q <= 1'b1;
            armed_q  <= 1'b0;
            run_q    <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end
      end
    end
  end

  // R1: opening follows a low sample on the synchronised pin
  a_r1_open_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> ($past(pin_s) == 1'b0));

  // R10: an exit request closes the port on the next cycle
  a_r10_clear_closes: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !active_q);

endmodule

// File: rtl/isp_cmd_core.sv
module isp_cmd_core
  import isp_seq_pkg::*;
#(
  parameter logic [7:0] OPT_RST = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic [7:0]  tx_data_o,
  output logic        fl_valid_o,
  input  logic        fl_ready_i,
  output fl_op_e      fl_op_o,
  output logic [15:0] fl_addr_o,
  output logic [7:0]  fl_wdata_o,
  input  logic        fl_done_i,
  input  logic [7:0]  fl_rdata_i,
  output logic [7:0]  timing_o,
  output logic        unlocked_o,
  output logic        reject_o,
  output logic        exit_o
);
  typedef enum logic [3:0] {
    S_OFF, S_OP, S_ARG, S_EXEC, S_FREQ, S_FWAIT, S_TXW, S_RXW, S_WDAT
  } state_e;

  state_e      state_q;
  logic [7:0]  op_q;
  logic [1:0]  argi_q;
  logic [15:0] addr_q;
  logic [7:0]  data_q;
  logic [7:0]  cnt_q;
  logic [7:0]  opt_q;
  logic [7:0]  timing_q;
  logic        first_ok_q;
  logic        key_q;
  logic        refuse_q;
  logic        reject_q;
  logic        exit_q;
  logic        fl_valid_q;
  fl_op_e      fl_op_q;
  logic [15:0] fl_addr_q;
  logic [7:0]  fl_wdata_q;
  logic        tx_valid_q;
  logic [7:0]  tx_data_q;
  logic [7:0]  rd_len;
  logic        opc_bad;

  assign rd_len     = (op_q == OPC_RD) ? 8'd1 : data_q;
  assign opc_bad    = !opcode_known(rx_data_i) || (!first_ok_q && rx_data_i != OPC_TIMING);
  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;
  assign fl_valid_o = fl_valid_q;
  assign fl_op_o    = fl_op_q;
  assign fl_addr_o  = fl_addr_q;
  assign fl_wdata_o = fl_wdata_q;
  assign timing_o   = timing_q;
  assign unlocked_o = key_q;
  assign reject_o   = reject_q;
  assign exit_o     = exit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_OFF;
      op_q       <= '0;
      argi_q     <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      cnt_q      <= '0;
      opt_q      <= OPT_RST;
      timing_q   <= '0;
      first_ok_q <= 1'b0;
      key_q      <= 1'b0;
      refuse_q   <= 1'b0;
      reject_q   <= 1'b0;
      exit_q     <= 1'b0;
      fl_valid_q <= 1'b0;
      fl_op_q    <= FL_READ;
      fl_addr_q  <= '0;
      fl_wdata_q <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      reject_q <= 1'b0;
      exit_q   <= 1'b0;
      case (state_q)
        S_OFF: begin
          first_ok_q <= 1'b0;
          key_q      <= 1'b0;
          if (active_i && !exit_q) state_q <= S_OP;
        end
        S_OP: if (rx_valid_i) begin
          op_q   <= rx_data_i;
          argi_q <= '0;
          if (opc_bad)                           reject_q <= 1'b1;
          else if (operand_bytes(rx_data_i) == 0) state_q <= S_EXEC;
          else                                    state_q <= S_ARG;
        end
        S_ARG: if (rx_valid_i) begin
          case (argi_q)
            2'd0: begin addr_q[15:8] <= rx_data_i; data_q <= rx_data_i; end
            2'd1: addr_q[7:0] <= rx_data_i;
            default: data_q <= rx_data_i;
          endcase
          argi_q <= argi_q + 2'd1;
          if (argi_q + 2'd1 == operand_bytes(op_q)) state_q <= S_EXEC;
        end
        S_EXEC: begin
          state_q <= S_OP;
          case (op_q)
            OPC_TIMING: begin
              timing_q   <= data_q;
              first_ok_q <= 1'b1;
            end
            OPC_KEY: key_q <= (data_q[7:2] == UNLOCK_PATTERN);
            OPC_MASS, OPC_PAGE: begin
              if (key_q) begin
                fl_valid_q <= 1'b1;
                fl_op_q    <= (op_q == OPC_MASS) ? FL_MASS_ERASE : FL_PAGE_ERASE;
                fl_addr_q  <= addr_q;
                state_q    <= S_FREQ;
              end else begin
                reject_q <= 1'b1;
              end
            end
            OPC_OPT: begin
              tx_data_q  <= opt_q;
              tx_valid_q <= 1'b1;
              cnt_q      <= '0;
              state_q    <= S_TXW;
            end
            OPC_RD, OPC_BRD: begin
              if (rd_len != 8'd0) begin
                fl_valid_q <= 1'b1;
                fl_op_q    <= FL_READ;
                fl_addr_q  <= addr_q;
                cnt_q      <= rd_len - 8'd1;
                state_q    <= S_FREQ;
              end
            end
            OPC_WR: begin
              if (key_q) begin
                fl_valid_q <= 1'b1;
                fl_op_q    <= FL_WRITE;
                fl_addr_q  <= addr_q;
                fl_wdata_q <= data_q;
                cnt_q      <= '0;
                state_q    <= S_FREQ;
              end else begin
                reject_q <= 1'b1;
              end
            end
            OPC_BWR: begin
              cnt_q    <= data_q;
              refuse_q <= !key_q;
              reject_q <= !key_q;
              if (data_q != 8'd0) state_q <= S_WDAT;
            end
            OPC_EXIT: begin
              exit_q  <= 1'b1;
              state_q <= S_OFF;
            end
            default: ;
          endcase
        end
        S_FREQ: if (fl_ready_i) begin
          fl_valid_q <= 1'b0;
          state_q    <= S_FWAIT;
        end
        S_FWAIT: if (fl_done_i) begin
          addr_q <= addr_q + 16'd1;
          case (fl_op_q)
            FL_READ: begin
              tx_data_q  <= fl_rdata_i;
              tx_valid_q <= 1'b1;
              state_q    <= S_TXW;
            end
            FL_WRITE: begin
              if (cnt_q == 8'd0) begin
                key_q   <= 1'b0;
                state_q <= S_OP;
              end else begin
                state_q <= S_WDAT;
              end
            end
            FL_PAGE_ERASE: begin
              key_q                <= 1'b0;
              opt_q[BOOT_FLAG_BIT] <= 1'b0;
              state_q              <= S_OP;
            end
            FL_MASS_ERASE: begin
              key_q                <= 1'b0;
              opt_q[BOOT_FLAG_BIT] <= 1'b0;
              opt_q[PROT_FLAG_BIT] <= 1'b0;
              state_q              <= S_OP;
            end
          endcase
        end
        S_TXW: if (tx_ready_i) begin
          tx_valid_q <= 1'b0;
          state_q    <= S_RXW;
        end
        S_RXW: if (rx_valid_i) begin
          if (cnt_q == 8'd0) begin
            state_q <= S_OP;
          end else begin
            fl_valid_q <= 1'b1;
            fl_op_q    <= FL_READ;
            fl_addr_q  <= addr_q;
            cnt_q      <= cnt_q - 8'd1;
            state_q    <= S_FREQ;
          end
        end
        S_WDAT: if (rx_valid_i) begin
          cnt_q <= cnt_q - 8'd1;
          if (refuse_q) begin
            if (cnt_q == 8'd1) state_q <= S_OP;
          end else begin
            fl_valid_q <= 1'b1;
            fl_op_q    <= FL_WRITE;
            fl_addr_q  <= addr_q;
            fl_wdata_q <= rx_data_i;
            state_q    <= S_FREQ;
          end
        end
        default: state_q <= S_OFF;
      endcase
    end
  end

  // R11: an unaccepted request holds all of its fields
  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid_o && !fl_ready_i) |=> (fl_valid_o && $stable(fl_addr_o)
                                     && $stable(fl_op_o) && $stable(fl_wdata_o)));

  // R11: nothing new is raised while one is in flight
  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FWAIT) |-> !fl_valid_o);

  // R4: modifying requests only ever appear while unlocked
  a_r4_locked_no_modify: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid_o && fl_op_o != FL_READ) |-> key_q);

  // R2: no flash traffic before the timing register was loaded
  a_r2_timing_first: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid_o |-> first_ok_q);

  // R10: exit leaves the core closed and locked
  a_r10_exit_lands_off: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |=> (state_q == S_OFF) && !unlocked_o && !exit_o);

endmodule

// File: rtl/isp_sequencer.sv
module isp_sequencer
  import isp_seq_pkg::*;
#(
  parameter int         DEB_LEN = 16,
  parameter logic [7:0] OPT_RST = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        entry_pin,
  input  logic        ser_clk,
  input  logic        ser_din,
  output logic        ser_dout,
  output logic        fl_valid,
  input  logic        fl_ready,
  output logic [1:0]  fl_op,
  output logic [15:0] fl_addr,
  output logic [7:0]  fl_wdata,
  input  logic        fl_done,
  input  logic [7:0]  fl_rdata,
  output logic        isp_active,
  output logic [7:0]  timing_val,
  output logic        wr_unlocked,
  output logic        cmd_reject,
  output logic        exit_reset
);
  logic       active_w;
  logic       rx_valid_w;
  logic [7:0] rx_data_w;
  logic       tx_valid_w;
  logic       tx_ready_w;
  logic [7:0] tx_data_w;
  logic       exit_w;
  fl_op_e     fl_op_w;

  assign isp_active = active_w;
  assign exit_reset = exit_w;
  assign fl_op      = fl_op_w;

  isp_entry_deb #(.DEB_LEN(DEB_LEN)) i_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (entry_pin),
    .clear_i  (exit_w),
    .active_o (active_w)
  );

  isp_ser_shift #(.BYTE_W(8)) i_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (active_w),
    .sclk_i     (ser_clk),
    .sdi_i      (ser_din),
    .sdo_o      (ser_dout),
    .rx_valid_o (rx_valid_w),
    .rx_data_o  (rx_data_w),
    .tx_valid_i (tx_valid_w),
    .tx_ready_o (tx_ready_w),
    .tx_data_i  (tx_data_w)
  );

  isp_cmd_core #(.OPT_RST(OPT_RST)) i_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active_w),
    .rx_valid_i (rx_valid_w),
    .rx_data_i  (rx_data_w),
    .tx_valid_o (tx_valid_w),
    .tx_ready_i (tx_ready_w),
    .tx_data_o  (tx_data_w),
    .fl_valid_o (fl_valid),
    .fl_ready_i (fl_ready),
    .fl_op_o    (fl_op_w),
    .fl_addr_o  (fl_addr),
    .fl_wdata_o (fl_wdata),
    .fl_done_i  (fl_done),
    .fl_rdata_i (fl_rdata),
    .timing_o   (timing_val),
    .unlocked_o (wr_unlocked),
    .reject_o   (cmd_reject),
    .exit_o     (exit_w)
  );

endmodule

// File: tb/test_isp_sequencer.sv
module test_isp_sequencer;
  localparam int DEB = 16;
  localparam int GAP = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry_pin = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_dout;
  logic        fl_valid;
  logic        fl_ready = 1'b0;
  logic [1:0]  fl_op;
  logic [15:0] fl_addr;
  logic [7:0]  fl_wdata;
  logic        fl_done = 1'b0;
  logic [7:0]  fl_rdata = 8'h00;
  logic        isp_active;
  logic [7:0]  timing_val;
  logic        wr_unlocked;
  logic        cmd_reject;
  logic        exit_reset;

  int tests = 0, fails = 0, req_cnt = 0, rej_cnt = 0, exit_cnt = 0;
  logic [7:0]  mem     [0:255];
  logic [7:0]  exp_mem [0:255];
  logic [1:0]  lg_op   [0:63];
  logic [15:0] lg_addr [0:63];
  logic [7:0]  lg_data [0:63];

  always #2 clk = ~clk;

  isp_sequencer i_isp_sequencer (
    .clk(clk), .rst_n(rst_n), .entry_pin(entry_pin), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .fl_valid(fl_valid), .fl_ready(fl_ready),
    .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_done(fl_done),
    .fl_rdata(fl_rdata), .isp_active(isp_active), .timing_val(timing_val),
    .wr_unlocked(wr_unlocked), .cmd_reject(cmd_reject), .exit_reset(exit_reset)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flash model, acting away from the active edge
  initial begin
    logic       v_prev = 1'b0, busy = 1'b0;
    logic [1:0] s_op = 2'd0;
    logic [15:0] s_addr = '0;
    logic [7:0] s_data = '0;
    int lat = 0, rwait = 0, k;
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    forever begin
      @(negedge clk);
      fl_done = 1'b0;
      if (busy) begin
        if (lat == 0) begin fl_done = 1'b1; busy = 1'b0; end
        else lat--;
      end else if (fl_ready && v_prev) begin
        k = req_cnt % 64;
        lg_op[k] = s_op; lg_addr[k] = s_addr; lg_data[k] = s_data;
        req_cnt++;
        if (s_op == 2'd1) mem[s_addr[7:0]] = s_data;
        fl_rdata = mem[s_addr[7:0]];
        fl_ready = 1'b0;
        busy = 1'b1;
        lat = int'($urandom % 5);
      end else if (fl_valid && !fl_ready) begin
        if (rwait == 0) begin fl_ready = 1'b1; rwait = int'($urandom % 3); end
        else rwait--;
      end
      v_prev = fl_valid; s_op = fl_op; s_addr = fl_addr; s_data = fl_wdata;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cmd_reject) rej_cnt++;
      if (exit_reset) exit_cnt++;
    end
  end

  task automatic xfer(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      ser_din = b[i];
      repeat (4) @(negedge clk);
      got[i] = ser_dout;
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (GAP) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    xfer(b, d);
  endtask

  task automatic enter();
    entry_pin = 1'b1;
    repeat (5) @(negedge clk);
    entry_pin = 1'b0;
    repeat (DEB + 6) @(negedge clk);
  endtask

  task automatic read_opt(input logic [7:0] exp, input string req);
    logic [7:0] d;
    send(8'h20);
    xfer(8'h00, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (800000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int r0, q0, e0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("reset isp_active", isp_active, 0);
    chk("reset fl_valid", fl_valid, 0);
    chk("reset exit_reset", exit_reset, 0);

    // R1: short low pulse, then bytes while closed
    entry_pin = 1'b0;
    repeat (8) @(negedge clk);
    entry_pin = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 short low keeps closed", isp_active, 0);
    send(8'h01); send(8'h77);
    chk("R1 closed bytes ignored", timing_val, 8'h00);
    chk("R1 closed no reject", rej_cnt, 0);
    entry_pin = 1'b0;
    repeat (DEB - 4) @(negedge clk);
    chk("R1 not yet open", isp_active, 0);
    repeat (10) @(negedge clk);
    chk("R1 open after debounce", isp_active, 1);

    // R2: first command must be timing write
    r0 = rej_cnt;
    send(8'h31);
    chk("R2 first non-timing rejected", rej_cnt, r0 + 1);
    chk("R2 no flash request", req_cnt, 0);
    send(8'h01); send(8'h5A);
    chk("R2 timing stored", timing_val, 8'h5A);

    // R12: unknown opcode
    r0 = rej_cnt;
    send(8'h44);
    chk("R12 unknown rejected", rej_cnt, r0 + 1);

    // R4: locked writes
    r0 = rej_cnt;
    send(8'h31); send(8'h00); send(8'h10); send(8'hEE);
    chk("R4 locked write rejected", rej_cnt, r0 + 1);
    send(8'h33); send(8'h00); send(8'h20); send(8'h02); send(8'h31); send(8'h31);
    chk("R4 locked burst rejected", rej_cnt, r0 + 2);
    chk("R4 no flash request", req_cnt, 0);
    read_opt(8'h03, "R4 framing kept / R9 reset option");

    // R3: key pattern
    send(8'h02); send(8'h9C);
    chk("R3 bad key stays locked", wr_unlocked, 0);
    send(8'h02); send(8'h9B);
    chk("R3 key with low bits 11", wr_unlocked, 1);
    send(8'h02); send(8'h9C);
    chk("R3 bad key closes", wr_unlocked, 0);
    send(8'h02); send(8'h98);
    chk("R3 key with low bits 00", wr_unlocked, 1);

    // R8 single write, R5 key consumed
    q0 = req_cnt;
    send(8'h31); send(8'h00); send(8'h10); send(8'hC5);
    exp_mem[8'h10] = 8'hC5;
    chk("R8 one request", req_cnt, q0 + 1);
    chk("R8 op write", lg_op[q0 % 64], 1);
    chk("R8 address", lg_addr[q0 % 64], 16'h0010);
    chk("R8 data", lg_data[q0 % 64], 8'hC5);
    chk("R5 lock after write", wr_unlocked, 0);

    // R6 single read
    send(8'h30); send(8'h00); send(8'h10);
    xfer(8'h00, d);
    chk("R6 read data", d, 8'hC5);
    chk("R6 op read", lg_op[req_cnt % 64 == 0 ? 63 : (req_cnt - 1) % 64], 0);

    // R7 zero-length burst read
    q0 = req_cnt;
    send(8'h32); send(8'h00); send(8'h40); send(8'h00);
    chk("R7 zero count no request", req_cnt, q0);
    send(8'h30); send(8'h00); send(8'h41);
    xfer(8'h00, d);
    chk("R7 framing after zero count", d, exp_mem[8'h41]);

    // random bursts
    for (int it = 0; it < 12; it++) begin
      int len, a;
      logic [7:0] hi;
      len = 1 + int'($urandom % 4);
      a = int'($urandom % 250);
      hi = 8'($urandom);
      send(8'h02); send(8'h98 | 8'($urandom % 4));
      q0 = req_cnt;
      send(8'h33); send(hi); send(8'(a)); send(8'(len));
      for (int j = 0; j < len; j++) begin
        logic [7:0] v;
        v = 8'($urandom);
        exp_mem[a + j] = v;
        send(v);
      end
      chk("R8 burst write count", req_cnt, q0 + len);
      chk("R8 burst last address", lg_addr[(q0 + len - 1) % 64], {hi, 8'(a + len - 1)});
      chk("R5 lock after burst write", wr_unlocked, 0);
      q0 = req_cnt;
      send(8'h32); send(hi); send(8'(a)); send(8'(len));
      for (int j = 0; j < len; j++) begin
        xfer(8'h00, d);
        chk("R7 burst read data", d, exp_mem[a + j]);
      end
      chk("R7 burst read count", req_cnt, q0 + len);
      chk("R7 burst last address", lg_addr[(q0 + len - 1) % 64], {hi, 8'(a + len - 1)});
    end

    // R9 erases and option byte
    r0 = rej_cnt;
    send(8'h11); send(8'h02); send(8'h00);
    chk("R4 locked page erase", rej_cnt, r0 + 1);
    send(8'h02); send(8'h99);
    q0 = req_cnt;
    send(8'h11); send(8'h02); send(8'h00);
    chk("R9 page erase op", lg_op[q0 % 64], 2);
    chk("R9 page erase address", lg_addr[q0 % 64], 16'h0200);
    chk("R5 lock after erase", wr_unlocked, 0);
    read_opt(8'h02, "R9 page erase clears boot flag only");
    send(8'h02); send(8'h9A);
    q0 = req_cnt;
    send(8'h10);
    chk("R9 mass erase op", lg_op[q0 % 64], 3);
    read_opt(8'h00, "R9 mass erase clears protection");

    // R10 exit
    e0 = exit_cnt;
    send(8'h7F);
    chk("R10 exit pulse", exit_cnt, e0 + 1);
    chk("R10 closed after exit", isp_active, 0);
    r0 = rej_cnt;
    send(8'h44);
    chk("R10 closed ignores bytes", rej_cnt, r0);
    enter();
    chk("R10 reopen", isp_active, 1);
    send(8'h30);
    chk("R10 timing write needed again", rej_cnt, r0 + 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule